// File: doc/BRIEF.md
# Serial CAN CRC-15 Frame Checker

This block verifies the cyclic redundancy check of a standard-format CAN data frame while the frame arrives one bit at a time. A receiver front end that has already removed stuff bits hands it a bit value with a per-bit valid strobe. It also supplies a frame-start pulse and the frame's data length code. The block hashes the frame from start-of-frame to the last data bit. It then collects the transmitted 15-bit check value, tests the delimiter that follows it, and reports the outcome on a one-cycle result strobe with a pass flag.

The hash is the CAN CRC-15: a 15-bit register starting at zero, generator 0x4599, one shift per accepted bit. A bit counter drives a small phase sequencer (idle, hash, capture, delimiter). The counter decides where hashing stops and capture begins, using the length implied by the data length code.

Top module: `can_crc15_checker`

## Requirements
- R1: While reset is low, and after it is released, `res_valid` and `crc_ok` read 0. Until the first `frame_start` pulse, accepted bits have no effect and produce no result strobe.
- R2: A `frame_start` pulse clears the CRC register and the bit counter and enters the hashing phase. A bit strobed in the same cycle as `frame_start` is dropped.
- R3: Each hashed bit updates the register as follows. Feedback is the bit XOR register bit 14. The register then shifts left with a 0 entering bit 0. When the feedback is 1, the result is XORed with 15'h4599. The frame is laid out as SOF, 11 identifier bits, RTR, IDE, r0, a 4-bit DLC, the data bits and a 15-bit CRC, all sent MSB first, followed by the delimiter.
- R4: A cycle with `bit_valid` low changes nothing, whatever value `bit_in` has.
- R5: Exactly 19 + 8 × min(`dlc`, 8) valid bits are hashed after `frame_start`. `dlc` must stay stable from `frame_start` to the end of the data field. DLC codes 9 to 15 hash 8 data bytes.
- R6: The next 15 valid bits are shifted in MSB first as the received CRC. They are compared for equality with the register value, which is held frozen from the end of the data field onward.
- R7: The valid bit after the received CRC is the delimiter. If it is 0, `crc_ok` is 0 even when the CRCs match.
- R8: In the cycle after the clock edge that accepts the delimiter, `res_valid` is high for exactly one cycle. `crc_ok` is 1 only when the CRCs match and the delimiter is 1, and `crc_ok` holds its value until the next result.
- R9: After the delimiter, accepted bits are ignored until the next `frame_start`. A `frame_start` in the middle of a frame abandons that frame and starts a new one.
- R10: The reset is synchronous and active low. Asserting it in the middle of a frame returns the block to idle with no result pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| bit_valid | input | 1 | Qualifies `bit_in` as a destuffed frame bit |
| bit_in | input | 1 | Received bit value |
| dlc | input | 4 | Data length code of the current frame |
| res_valid | output | 1 | One-cycle result strobe |
| crc_ok | output | 1 | Result: CRC matched and delimiter recessive |

## Verification
A wrong register or counter state inside the block becomes visible at only one point: the single result strobe of the frame. That strobe comes one cycle after the delimiter edge. A counter that is off by one bit shifts the hash/capture boundary, so correct frames report `crc_ok` = 0, or the strobe appears one valid bit early or late. A wrong CRC update flips `crc_ok` for the frame. The bench therefore compares every frame's strobe timing and flag with a CRC computed by polynomial long division. It uses single-bit corruptions at the hashed and captured boundaries to show the flag reacts to each field.

// File: rtl/can_crc15_pkg.sv
package can_crc15_pkg;
  localparam int CRC_W     = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
  localparam int HDR_BITS  = 19;
  localparam int MAX_BYTES = 8;
  localparam int DLC_W     = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HASH  = 2'd1,
    PH_CAPT  = 2'd2,
    PH_DELIM = 2'd3
  } phase_e;

  // One serial CRC step: feedback = bit ^ msb, shift left, conditional XOR.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic bit_v);
    logic fb;
    logic [CRC_W-1:0] nxt;
    fb  = bit_v ^ cur[CRC_W-1];
    nxt = {cur[CRC_W-2:0], 1'b0};
    if (fb) nxt = nxt ^ CRC_POLY;
    return nxt;
  endfunction

  // Number of hashed bits: header plus clamped data bytes.
  function automatic int unsigned hashed_len(input logic [DLC_W-1:0] code);
    int unsigned nb;
    nb = (int'(code) > MAX_BYTES) ? MAX_BYTES : int'(code);
    return HDR_BITS + 8 * nb;
  endfunction
endpackage

// File: rtl/crc15_engine.sv
module crc15_engine
  import can_crc15_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc <= '0;
    else if (advance)    crc <= crc_step(crc, bit_in);
  end

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> crc == '0);

  assert_hold_without_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !advance) |=> $stable(crc));
endmodule

// File: rtl/crc_frame_seq.sv
module crc_frame_seq
  import can_crc15_pkg::*;
#(
  parameter int HDR     = HDR_BITS,
  parameter int BYTES   = MAX_BYTES,
  parameter int CW      = CRC_W,
  localparam int MAXLEN = HDR + 8 * BYTES,
  localparam int CNT_W  = $clog2(MAXLEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             bit_valid,
  input  logic [DLC_W-1:0] dlc,
  output phase_e           phase,
  output logic             hash_en,
  output logic             capt_en,
  output logic             delim_en
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_hash;
  logic             take;

  assign take      = bit_valid && !frame_start;
  assign hash_en   = take && (phase == PH_HASH);
  assign capt_en   = take && (phase == PH_CAPT);
  assign delim_en  = take && (phase == PH_DELIM);
  assign last_hash = CNT_W'(hashed_len(dlc) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (frame_start) begin
      phase <= PH_HASH;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_HASH: if (hash_en) begin
          if (cnt == last_hash) begin
            phase <= PH_CAPT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_CAPT: if (capt_en) begin
          if (cnt == CNT_W'(CW - 1)) begin
            phase <= PH_DELIM;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_DELIM: if (delim_en) phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  assert_start_enters_hash_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (phase == PH_HASH) && (cnt == '0));

  assert_hash_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HASH) |-> (cnt <= last_hash));

  assert_capture_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CAPT) |-> (cnt < CNT_W'(CW)));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !frame_start) |=> (phase == PH_IDLE));
endmodule

// File: rtl/can_crc15_checker.sv
module can_crc15_checker
  import can_crc15_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic [3:0] dlc,
  output logic       res_valid,
  output logic       crc_ok
);
  phase_e           phase;
  logic             hash_en, capt_en, delim_en;
  logic [CRC_W-1:0] crc_calc;
  logic [CRC_W-1:0] crc_rx;
  logic             crc_equal;

  crc_frame_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .bit_valid   (bit_valid),
    .dlc         (dlc),
    .phase       (phase),
    .hash_en     (hash_en),
    .capt_en     (capt_en),
    .delim_en    (delim_en)
  );

  crc15_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (frame_start),
    .advance (hash_en),
    .bit_in  (bit_in),
    .crc     (crc_calc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) crc_rx <= '0;
    else if (capt_en)          crc_rx <= {crc_rx[CRC_W-2:0], bit_in};
  end

  assign crc_equal = (crc_rx == crc_calc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      crc_ok    <= 1'b0;
    end else begin
      res_valid <= delim_en;
      if (delim_en) crc_ok <= crc_equal && bit_in;
    end
  end

  assert_single_cycle_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_strobe_after_delim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(delim_en));

  assert_ok_holds_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !delim_en |=> $stable(crc_ok));

  assert_crc_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_CAPT || phase == PH_DELIM) && !frame_start) |=> $stable(crc_calc));

  assert_bad_delim_fails_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (delim_en && !bit_in) |=> !crc_ok);
endmodule

// File: tb/can_crc15_checker_bench.sv
module can_crc15_checker_bench;
  logic clk = 1'b0;
  logic rst_n, frame_start, bit_valid, bit_in;
  logic [3:0] dlc;
  logic res_valid, crc_ok;
  int checks = 0, failures = 0, strobes = 0;

  always #2 clk = ~clk;

  can_crc15_checker u_can_crc15_checker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_valid(bit_valid),
    .bit_in(bit_in), .dlc(dlc), .res_valid(res_valid), .crc_ok(crc_ok)
  );

  always @(negedge clk) if (res_valid) strobes++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference CRC by long division of the augmented message, divisor 0xC599.
  function automatic logic [14:0] ref_crc(input logic fb [0:127], input int n);
    logic [15:0] rem = '0;
    for (int i = 0; i < n + 15; i++) begin
      rem = {rem[14:0], (i < n) ? fb[i] : 1'b0};
      if (rem[15]) rem = rem ^ 16'hC599;
    end
    return rem[14:0];
  endfunction

  task automatic send_bit(input logic b, input bit gap);
    if (gap) begin
      bit_valid = 1'b0; bit_in = ~b;
      @(negedge clk);
    end
    bit_valid = 1'b1; bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic pulse_start();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // Sends a complete frame and checks strobe timing and flag.
  task automatic run_frame(input string req, input logic [10:0] id, input logic [3:0] code,
                           input logic [63:0] data, input int flip_idx, input int crc_flip,
                           input logic delim, input bit gap, input int exp_ok);
    logic fb [0:127];
    logic [14:0] crc;
    int n, nb, s0;
    nb = (code > 8) ? 8 : int'(code);
    n = 19 + 8 * nb;
    fb[0] = 1'b0;
    for (int i = 0; i < 11; i++) fb[1 + i] = id[10 - i];
    fb[12] = 1'b0; fb[13] = 1'b0; fb[14] = 1'b0;
    for (int i = 0; i < 4; i++) fb[15 + i] = code[3 - i];
    for (int i = 0; i < 8 * nb; i++) fb[19 + i] = data[63 - i];
    crc = ref_crc(fb, n);
    if (flip_idx >= 0) fb[flip_idx] = ~fb[flip_idx];
    if (crc_flip >= 0) crc[14 - crc_flip] = ~crc[14 - crc_flip];
    dlc = code;
    pulse_start();
    s0 = strobes;
    for (int i = 0; i < n; i++) send_bit(fb[i], gap);
    for (int i = 0; i < 15; i++) send_bit(crc[14 - i], gap);
    chk({req, " no strobe before delimiter"}, strobes - s0, 0);
    send_bit(delim, gap);
    chk({req, " strobe after delimiter"}, int'(res_valid), 1);
    chk({req, " crc_ok"}, int'(crc_ok), exp_ok);
    @(negedge clk);
    chk({req, " R8 strobe one cycle"}, int'(res_valid), 0);
    chk({req, " R8 crc_ok held"}, int'(crc_ok), exp_ok);
  endtask

  task automatic test_reset();
    chk("R1 res_valid in reset", int'(res_valid), 0);
    chk("R1 crc_ok in reset", int'(crc_ok), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 60; i++) send_bit(i[0], 1'b0);
    chk("R1 no strobe before frame_start", strobes, 0);
  endtask

  task automatic test_ignore_after();
    int s0 = strobes;
    for (int i = 0; i < 40; i++) send_bit(i[1], 1'b0);
    chk("R9 bits after result ignored", strobes - s0, 0);
  endtask

  task automatic test_restart();
    pulse_start();
    for (int i = 0; i < 30; i++) send_bit(1'b1, 1'b0);
    run_frame("R9 restart mid-frame", 11'h2A5, 4'd2, 64'hC3A5_0000_0000_0000, -1, -1, 1'b1, 1'b0, 1);
  endtask

  task automatic test_start_with_bit();
    frame_start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; bit_valid = 1'b0;
    run_frame("R2 start clears state", 11'h001, 4'd1, 64'h8000_0000_0000_0000, -1, -1, 1'b1, 1'b0, 1);
  endtask

  task automatic test_reset_mid_frame();
    int s0;
    dlc = 4'd0;
    pulse_start();
    for (int i = 0; i < 33; i++) send_bit(1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    s0 = strobes;
    for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0);
    chk("R10 reset mid-frame leaves idle", strobes - s0, 0);
    chk("R10 crc_ok cleared", int'(crc_ok), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; dlc = 4'd0;
    repeat (3) @(negedge clk);
    test_reset();
    run_frame("R3 R5 dlc8", 11'h123, 4'd8, 64'h0123_4567_89AB_CDEF, -1, -1, 1'b1, 1'b0, 1);
    test_ignore_after();
    run_frame("R5 dlc0", 11'h7FF, 4'd0, 64'h0, -1, -1, 1'b1, 1'b0, 1);
    run_frame("R5 dlc3", 11'h555, 4'd3, 64'hFFEE_DD00_0000_0000, -1, -1, 1'b1, 1'b0, 1);
    run_frame("R5 dlc12 clamps", 11'h0F0, 4'd12, 64'hDEAD_BEEF_0BAD_F00D, -1, -1, 1'b1, 1'b0, 1);
    run_frame("R4 gaps with noise", 11'h3C3, 4'd5, 64'h1122_3344_5500_0000, -1, -1, 1'b1, 1'b1, 1);
    run_frame("R3 flip SOF", 11'h123, 4'd8, 64'h0123_4567_89AB_CDEF, 0, -1, 1'b1, 1'b0, 0);
    run_frame("R3 flip id bit", 11'h123, 4'd8, 64'h0123_4567_89AB_CDEF, 6, -1, 1'b1, 1'b0, 0);
    run_frame("R5 flip last hashed", 11'h123, 4'd2, 64'hABCD_0000_0000_0000, 34, -1, 1'b1, 1'b0, 0);
    run_frame("R6 flip crc msb", 11'h456, 4'd4, 64'h0102_0304_0000_0000, -1, 0, 1'b1, 1'b0, 0);
    run_frame("R6 flip crc lsb", 11'h456, 4'd4, 64'h0102_0304_0000_0000, -1, 14, 1'b1, 1'b0, 0);
    run_frame("R7 dominant delimiter", 11'h456, 4'd4, 64'h0102_0304_0000_0000, -1, -1, 1'b0, 1'b0, 0);
    test_restart();
    test_start_with_bit();
    test_reset_mid_frame();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule